// File: doc/BRIEF.md
# Sequential Integer Divider

The block computes the quotient or the remainder of two 32-bit integers, either as signed or as unsigned values. A one-cycle start pulse loads both operands and a 2-bit operation code. The block then steps through a fixed schedule and raises `valid_o` for a single cycle, with the answer on `result_o`.

The schedule runs as follows. Cycle 0 tests the divisor for zero. Cycle 1 either returns the zero-divisor answer at once or converts the dividend to its magnitude. Cycle 2 converts the divisor to its magnitude. Cycle 3 clears the partial remainder. Cycles 4 to 35 produce one quotient bit each, using restoring subtraction. Cycle 36 applies the sign correction and presents the result.

A single conditional negator serves all three sign steps. The control FSM decides which value it sees in each cycle.

Top module: `sdiv_core`

## Requirements
- R1: After reset `valid_o` is 0, and `result_o` reads 0 whenever `valid_o` is 0.
- R2: `op_i` bit 0 selects the remainder (1) or the quotient (0). `op_i` bit 1 selects unsigned (1) or signed two's complement (0) operands. Both are sampled with the operands on the start cycle.
- R3: Unsigned operations return floor(a/b) and a mod b, with no sign handling.
- R4: Signed operations truncate toward zero. The quotient is negative when the operand signs differ, and a nonzero remainder carries the sign of the dividend.
- R5: With a zero divisor the quotient is all ones and the remainder equals the dividend exactly as supplied, in both signed and unsigned modes.
- R6: A zero-divisor operation raises `valid_o` in cycle 1, so it takes 2 cycles counting the capture cycle as cycle 0.
- R7: Any operation with a nonzero divisor raises `valid_o` in cycle 36, so it takes 37 cycles.
- R8: Signed division of 0x80000000 by 0xFFFFFFFF returns quotient 0x80000000 and remainder 0.
- R9: A start pulse that arrives while an operation is in progress has no effect on that result, its timing, or on any later output.
- R10: `valid_o` is high for exactly one cycle per accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when idle |
| op_i | input | 2 | Bit 0: remainder select; bit 1: unsigned select |
| dividend_i | input | 32 | Dividend, sampled on an accepted start |
| divisor_i | input | 32 | Divisor, sampled on an accepted start |
| valid_o | output | 1 | One-cycle completion strobe |
| result_o | output | 32 | Quotient or remainder while `valid_o` is high, else 0 |

## Verification
The assertions assume that operands and the operation code matter only in the cycle where a start pulse is accepted. They also assume that `start_i` may be driven in any cycle, busy or not. The cycle-count property therefore measures from acceptance, never from a raw start pulse. The stimulus changes inputs only at falling edges. It deliberately pulses start in the middle of an operation, using different operands, so the ignore path is exercised with inputs that would change the answer if they were taken.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHK, ST_ABSA, ST_ABSB, ST_INIT, ST_DIV, ST_FIN
  } div_state_e;
  localparam int unsigned OP_REM_BIT = 0;
  localparam int unsigned OP_UNS_BIT = 1;
endpackage

// File: rtl/sdiv_negate.sv
module sdiv_negate #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         neg_i,
  output logic [W-1:0] val_o
);
  assign val_o = neg_i ? (~val_i + W'(1)) : val_i;
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0] shifted;
  logic [W:0] trial;
  assign shifted = {rem_i, quo_i[W-1]};
  assign trial   = shifted - {1'b0, den_i};
  // borrow in trial[W] -> restore
  assign rem_o = trial[W] ? shifted[W-1:0] : trial[W-1:0];
  assign quo_o = {quo_i[W-2:0], ~trial[W]};
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core
  import sdiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         valid_o,
  output logic [W-1:0] result_o
);
  localparam int unsigned CNT_W = $clog2(W);

  div_state_e       state_q;
  logic [1:0]       op_q;
  logic [W-1:0]     a_q, b_q, rem_q, quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             div0_q, neg_quo_q, neg_rem_q;

  logic [W-1:0] neg_in, neg_out, rem_nxt, quo_nxt;
  logic         neg_en, is_signed, want_rem;

  assign is_signed = ~op_q[OP_UNS_BIT];
  assign want_rem  = op_q[OP_REM_BIT];

  // one negator shared by both magnitude steps and the sign fix
  always_comb begin
    unique case (state_q)
      ST_ABSA: begin neg_in = a_q; neg_en = is_signed & a_q[W-1]; end
      ST_ABSB: begin neg_in = b_q; neg_en = is_signed & b_q[W-1]; end
      default: begin
        neg_in = want_rem ? rem_q : quo_q;
        neg_en = want_rem ? neg_rem_q : neg_quo_q;
      end
    endcase
  end

  sdiv_negate #(.W(W)) u_neg (.val_i(neg_in), .neg_i(neg_en), .val_o(neg_out));

  sdiv_step #(.W(W)) u_step (
    .rem_i(rem_q), .quo_i(quo_q), .den_i(b_q),
    .rem_o(rem_nxt), .quo_o(quo_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      a_q       <= '0;
      b_q       <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      cnt_q     <= '0;
      div0_q    <= 1'b0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_CHK;
          op_q      <= op_i;
          a_q       <= dividend_i;
          b_q       <= divisor_i;
          neg_quo_q <= ~op_i[OP_UNS_BIT] & (dividend_i[W-1] ^ divisor_i[W-1]);
          neg_rem_q <= ~op_i[OP_UNS_BIT] & dividend_i[W-1];
        end
        ST_CHK: begin
          div0_q  <= (b_q == '0);
          state_q <= ST_ABSA;
        end
        ST_ABSA: begin
          if (div0_q) begin
            state_q <= ST_IDLE;
          end else begin
            a_q     <= neg_out;
            state_q <= ST_ABSB;
          end
        end
        ST_ABSB: begin
          b_q     <= neg_out;
          state_q <= ST_INIT;
        end
        ST_INIT: begin
          rem_q   <= '0;
          quo_q   <= a_q;
          cnt_q   <= '0;
          state_q <= ST_DIV;
        end
        ST_DIV: begin
          rem_q <= rem_nxt;
          quo_q <= quo_nxt;
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(W-1)) state_q <= ST_FIN;
        end
        ST_FIN: begin
          div0_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    valid_o  = 1'b0;
    result_o = '0;
    if (state_q == ST_FIN) begin
      valid_o  = 1'b1;
      result_o = neg_out;
    end else if (state_q == ST_ABSA && div0_q) begin
      valid_o  = 1'b1;
      result_o = want_rem ? a_q : '1;
    end
  end
endmodule

// File: rtl/sdiv_core_chk.sv
module sdiv_core_chk
  import sdiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input div_state_e   state_q,
  input logic         div0_q,
  input logic [1:0]   op_q,
  input logic [W-1:0] b_q,
  input logic         valid_o,
  input logic [W-1:0] result_o
);
  localparam int unsigned LAT   = W + 4;
  localparam int unsigned CYC_W = $clog2(W + 8) + 1;

  logic [CYC_W-1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (state_q == ST_IDLE && start_i) cyc_q <= '0;
    else if (cyc_q != '1) cyc_q <= cyc_q + CYC_W'(1);
  end

  assert_quiet_result_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> result_o == '0);
  assert_div0_quotient_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && div0_q && !op_q[OP_REM_BIT]) |-> result_o == '1);
  assert_div0_fast_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHK && b_q == '0) |=> valid_o);
  assert_full_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !div0_q) |-> cyc_q == CYC_W'(LAT));
  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> state_q != ST_CHK);
  assert_single_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

bind sdiv_core sdiv_core_chk #(.W(W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .state_q(state_q),
  .div0_q(div0_q), .op_q(op_q), .b_q(b_q), .valid_o(valid_o), .result_o(result_o)
);

// File: tb/sdiv_core_tb_top.sv
`timescale 1ns/1ps
module sdiv_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic        valid;
  logic [31:0] result;
  int          errors = 0;
  int          checks = 0;

  always #2 clk = ~clk;

  sdiv_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .dividend_i(a), .divisor_i(b), .valid_o(valid), .result_o(result)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
    longint sx, sy, q, r;
    if (y == 0) return o[0] ? x : 32'hFFFF_FFFF;
    if (o[1]) return o[0] ? (x % y) : (x / y);
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    q = sx / sy;
    r = sx % sy;
    return o[0] ? r[31:0] : q[31:0];
  endfunction

  // launches one op; returns the cycle count and the result
  task automatic launch(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                        output int cyc, output logic [31:0] res);
    int k;
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    start = 1'b0; op = 2'b00; a = '0; b = '0;
    k = 0;
    while (!valid && k < 60) begin
      @(negedge clk);
      k++;
    end
    cyc = k + 1;
    res = result;
    @(negedge clk);
    check("R10 strobe drops", {31'b0, valid}, 32'd0);
  endtask

  task automatic run_op(input string req, input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
    int cyc;
    logic [31:0] res;
    launch(o, x, y, cyc, res);
    check(req, res, model(o, x, y));
    if (y == 0) check("R6 zero-divisor cycles", cyc, 2);
    else        check("R7 cycles", cyc, 37);
  endtask

  task automatic t_reset;
    check("R1 valid after reset", {31'b0, valid}, 32'd0);
    check("R1 result after reset", result, 32'd0);
  endtask

  task automatic t_unsigned;
    run_op("R3 udiv", 2'b10, 32'd100, 32'd7);
    run_op("R3 urem", 2'b11, 32'd100, 32'd7);
    run_op("R3 udiv large", 2'b10, 32'hFFFF_FFFF, 32'd3);
    run_op("R3 urem top bit", 2'b11, 32'h8000_0001, 32'h8000_0000);
    run_op("R3 udiv small by large", 2'b10, 32'd5, 32'hFFFF_FFF0);
  endtask

  task automatic t_signed;
    run_op("R4 sdiv neg/pos", 2'b00, -32'sd100, 32'sd7);
    run_op("R4 srem neg/pos", 2'b01, -32'sd100, 32'sd7);
    run_op("R4 sdiv pos/neg", 2'b00, 32'sd100, -32'sd7);
    run_op("R4 srem pos/neg", 2'b01, 32'sd100, -32'sd7);
    run_op("R4 sdiv neg/neg", 2'b00, -32'sd100, -32'sd7);
    run_op("R4 srem neg/neg", 2'b01, -32'sd100, -32'sd7);
    run_op("R2 signed vs unsigned code", 2'b10, -32'sd100, 32'sd7);
  endtask

  task automatic t_zero;
    run_op("R5 sdiv by zero", 2'b00, 32'h1234_5678, 32'd0);
    run_op("R5 srem by zero", 2'b01, 32'h8765_4321, 32'd0);
    run_op("R5 udiv by zero", 2'b10, 32'd0, 32'd0);
    run_op("R5 urem by zero", 2'b11, 32'hDEAD_BEEF, 32'd0);
  endtask

  task automatic t_overflow;
    int cyc;
    logic [31:0] res;
    launch(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, cyc, res);
    check("R8 overflow quotient", res, 32'h8000_0000);
    launch(2'b01, 32'h8000_0000, 32'hFFFF_FFFF, cyc, res);
    check("R8 overflow remainder", res, 32'd0);
  endtask

  task automatic t_busy_start;
    int k;
    logic [31:0] res;
    int extra;
    @(negedge clk);
    start = 1'b1; op = 2'b10; a = 32'd1000; b = 32'd9;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; op = 2'b11; a = 32'd77; b = 32'd0;
    @(negedge clk);
    start = 1'b0; op = 2'b00; a = '0; b = '0;
    k = 6;
    while (!valid && k < 60) begin
      @(negedge clk);
      k++;
    end
    res = result;
    check("R9 first result kept", res, 32'd111);
    check("R9 first timing kept", k + 1, 37);
    extra = 0;
    for (int i = 0; i < 45; i++) begin
      @(negedge clk);
      if (valid) extra++;
    end
    check("R9 no second completion", extra, 0);
  endtask

  task automatic t_sweep;
    logic [31:0] x = 32'hACE1_2468;
    logic [31:0] y = 32'h0000_1357;
    for (int i = 0; i < 16; i++) begin
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
      y = {y[30:0], y[31] ^ y[21] ^ y[1] ^ y[0]};
      run_op("R2 sweep", 2'(i), x, (i % 4 == 3) ? (y >> (i % 28)) : y);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_signed();
    t_zero();
    t_overflow();
    t_busy_start();
    t_sweep();
    summary();
  end
endmodule